// File: doc/BRIEF.md
# Masked-Access GPIO Port Controller

An eight-pin general-purpose I/O port attached to a simple 32-bit memory-mapped register bus. Software sets each pin as input or output, drives output levels, samples input levels and watches pins for interrupt events. Reads and writes to the data window take their pin mask from address bits [9:2]. One bus access can therefore update or sample any subset of pins without a read-modify-write sequence, so other software contexts touching other pins are never disturbed.

Each pin has its own trigger setup. A pin can watch for a low level, a high level, a falling edge, a rising edge or both edges. Edge events are latched and stay until software acknowledges them by writing ones to the clear register. Level conditions track the synchronised pin directly. A per-pin enable selects which raw conditions reach the masked status and the single combined interrupt line.

Top module: `gpio_mask_port`

## Requirements
- R1: After synchronous reset every register holds zero: all pins are inputs (pin_oe = 0x00), every interrupt enable is off, no status bit is set and irq is low.
- R2: Direction register (offset 0x400) bit n = 1 makes pin n an output. pin_oe[n] is then high and pin_out[n] carries data bit n.
- R3: A write to the data window (addr[11:10] = 0) uses addr[9:2] as a pin mask. Pins whose mask bit is 1 take the written data bit. Pins whose mask bit is 0 keep their previous output value.
- R4: A read of the data window returns 0 for pins whose mask bit (addr[9:2]) is 0. A masked-in output pin returns its driven value. A masked-in input pin returns its input after a two-flop synchroniser, so a change is visible from the second rising clock edge after it.
- R5: Sense register (0x404) bit = 1 selects level detection. Polarity register (0x40C) bit = 1 means high level and 0 means low level. The raw status then follows the synchronised level, and writing the clear register does not remove it.
- R6: Sense bit = 0 with the both-edges bit (0x408) = 0 selects a single edge: polarity 1 means rising and 0 means falling. A detected edge latches the raw status bit.
- R7: Both-edges bit = 1 on an edge pin latches on rising and on falling edges, and the polarity bit is ignored.
- R8: Writing 1 to a bit of the clear register (0x41C) clears that latched edge flag. Writing 0 has no effect. An edge detected in the same cycle as its clear leaves the flag set.
- R9: Raw status (0x414) and masked status (0x418) are readable. Masked status equals raw status AND the interrupt enable register (0x410). irq is high while any masked status bit is set and stays high until the condition is cleared.
- R10: Unmapped offsets and the clear register read as zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | 8 | Asynchronous pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded assertions check on every cycle that a masked data write leaves the unselected output bits alone. They also check that an edge flag rises only after a detected event, that a clear always loses to a simultaneous edge while a clear with no edge always removes the flag, that writes to unmapped offsets leave the configuration unchanged, and that irq never rises without an enabled pin. Only the bench scenarios can show the sequence of accumulated masked writes, the exact two-cycle synchroniser latency on reads, the choice among the five trigger modes with polarity ignored for both-edges pins, the persistence of level conditions against clears, and the exact cycle on which a same-cycle clear meets an edge.

// File: rtl/gmp_pkg.sv
package gmp_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_DIR   = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_SENSE = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_BOTH  = 12'h408;
    localparam logic [ADDR_W-1:0] OFF_POL   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h410;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFF_MIS   = 12'h418;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h41C;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_DIR, SEL_SENSE, SEL_BOTH,
        SEL_POL, SEL_MASK, SEL_RAW, SEL_MIS, SEL_CLR
    } reg_sel_e;

    // per-pin trigger setup
    typedef struct packed {
        logic sense;   // 1 = level, 0 = edge
        logic both;    // edge on either transition
        logic pol;     // 1 = high / rising, 0 = low / falling
    } trig_cfg_t;

    function automatic reg_sel_e decode_reg(logic [ADDR_W-1:0] a, int unsigned data_hi);
        reg_sel_e s;
        if ((a >> data_hi) == '0) begin
            s = SEL_DATA;
        end else begin
            unique case (a)
                OFF_DIR:   s = SEL_DIR;
                OFF_SENSE: s = SEL_SENSE;
                OFF_BOTH:  s = SEL_BOTH;
                OFF_POL:   s = SEL_POL;
                OFF_MASK:  s = SEL_MASK;
                OFF_RAW:   s = SEL_RAW;
                OFF_MIS:   s = SEL_MIS;
                OFF_CLR:   s = SEL_CLR;
                default:   s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic pick_event(logic rise, logic fall, trig_cfg_t c);
        logic e;
        if (c.both) e = rise | fall;
        else        e = c.pol ? rise : fall;
        return e;
    endfunction

endpackage

// File: rtl/gmp_sync.sv
module gmp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gmp_detect.sv
module gmp_detect
    import gmp_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PINS-1:0]       lvl,
    input  trig_cfg_t [PINS-1:0]  cfg,
    input  logic [PINS-1:0]       clr,
    output logic [PINS-1:0]       raw
);
    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] flag_q;
    logic [PINS-1:0] evt;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic rise, fall;
        assign rise   = lvl[i] & ~prev_q[i];
        assign fall   = ~lvl[i] & prev_q[i];
        assign evt[i] = pick_event(rise, fall, cfg[i]);

        always_ff @(posedge clk) begin
            if (rst)         flag_q[i] <= 1'b0;
            else if (evt[i]) flag_q[i] <= 1'b1;   // new edge beats clear
            else if (clr[i]) flag_q[i] <= 1'b0;
        end

        assign raw[i] = cfg[i].sense ? (lvl[i] == cfg[i].pol) : flag_q[i];

        AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
            (evt[i] && clr[i]) |=> flag_q[i]);                         // R8
        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !evt[i]) |=> !flag_q[i]);                       // R8
        AST_FLAG_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_q[i]) |-> $past(evt[i]));                       // R6
    end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gmp_pkg::*;
#(
    parameter int PINS      = 8,
    parameter int DATA_W    = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    localparam int MASK_LO = 2;
    localparam int DATA_HI = MASK_LO + PINS;

    logic [PINS-1:0] dir_q, dout_q, sense_q, both_q, pol_q, mask_q;
    logic [PINS-1:0] lvl_sync, raw, mis, clr_pulse, acc_mask, wr_bits;
    trig_cfg_t [PINS-1:0] cfg;
    reg_sel_e sel;
    logic wr_en, data_wr;

    assign sel      = decode_reg(bus_addr, DATA_HI);
    assign acc_mask = bus_addr[DATA_HI-1:MASK_LO];
    assign wr_en    = bus_sel & bus_wr;
    assign wr_bits  = bus_wdata[PINS-1:0];
    assign data_wr  = wr_en && (sel == SEL_DATA);

    gmp_sync #(.W(PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk), .rst (rst), .d (pin_in), .q (lvl_sync)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_cfg
        assign cfg[i] = '{sense: sense_q[i], both: both_q[i], pol: pol_q[i]};
    end

    assign clr_pulse = (wr_en && sel == SEL_CLR) ? wr_bits : '0;

    gmp_detect #(.PINS(PINS)) u_detect (
        .clk (clk), .rst (rst), .lvl (lvl_sync),
        .cfg (cfg), .clr (clr_pulse), .raw (raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            dout_q  <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DATA:  dout_q  <= (dout_q & ~acc_mask) | (wr_bits & acc_mask);
                SEL_DIR:   dir_q   <= wr_bits;
                SEL_SENSE: sense_q <= wr_bits;
                SEL_BOTH:  both_q  <= wr_bits;
                SEL_POL:   pol_q   <= wr_bits;
                SEL_MASK:  mask_q  <= wr_bits;
                default: ;
            endcase
        end
    end

    assign mis = raw & mask_q;
    assign irq = |mis;

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_DATA:  bus_rdata[PINS-1:0] = acc_mask & ((dir_q & dout_q) | (~dir_q & lvl_sync));
            SEL_DIR:   bus_rdata[PINS-1:0] = dir_q;
            SEL_SENSE: bus_rdata[PINS-1:0] = sense_q;
            SEL_BOTH:  bus_rdata[PINS-1:0] = both_q;
            SEL_POL:   bus_rdata[PINS-1:0] = pol_q;
            SEL_MASK:  bus_rdata[PINS-1:0] = mask_q;
            SEL_RAW:   bus_rdata[PINS-1:0] = raw;
            SEL_MIS:   bus_rdata[PINS-1:0] = mis;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

    AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> ((dout_q & ~$past(acc_mask)) == ($past(dout_q) & ~$past(acc_mask)))); // R3
    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(dout_q) && $stable(mask_q)
                                        && $stable(sense_q) && $stable(both_q) && $stable(pol_q))); // R10
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q != '0));                                       // R9
endmodule

// File: tb/sim_gpio_mask_port.sv
module sim_gpio_mask_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        irq;
    int checks = 0, errors = 0;
    logic [31:0] rd;

    localparam logic [11:0] A_DIR = 12'h400, A_SEN = 12'h404, A_BOTH = 12'h408,
                            A_POL = 12'h40C, A_MSK = 12'h410, A_RAW = 12'h414,
                            A_MIS = 12'h418, A_CLR = 12'h41C;

    // {pin mask, write data, expected outputs after the write}
    localparam logic [23:0] VEC [0:5] = '{
        24'hFF_A5_A5, 24'h0F_00_A0, 24'hF0_FF_F0,
        24'h81_FF_F1, 24'h00_FF_F1, 24'h3C_00_C1 };

    always #4 clk = ~clk;

    gpio_mask_port u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drive_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
    endtask

    function automatic logic [11:0] dwin(input logic [7:0] m);
        return {2'b00, m, 2'b00};
    endfunction

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rdreg(A_DIR, rd);  chk("R1 dir", rd, 0);
        rdreg(A_MSK, rd);  chk("R1 mask", rd, 0);
        rdreg(A_RAW, rd);  chk("R1 raw", rd, 0);
        chk("R1 oe", {24'h0, pin_oe}, 0);
        chk("R1 irq", {31'h0, irq}, 0);

        // R2 R3 vector walk, all pins outputs
        wr(A_DIR, 32'hFF);
        chk("R2 oe all", {24'h0, pin_oe}, 32'hFF);
        foreach (VEC[k]) begin
            wr(dwin(VEC[k][23:16]), {24'h0, VEC[k][15:8]});
            chk($sformatf("R3 vec%0d pin_out", k), {24'h0, pin_out}, {24'h0, VEC[k][7:0]});
            rdreg(dwin(8'hFF), rd);
            chk($sformatf("R4 vec%0d readback", k), rd, {24'h0, VEC[k][7:0]});
        end

        // R4 mixed direction, sync latency, masked read
        wr(A_DIR, 32'hF0);
        chk("R2 oe half", {24'h0, pin_oe}, 32'hF0);
        chk("R2 out", {24'h0, pin_out}, 32'hC1);
        @(negedge clk); pin_in = 8'hF5;
        repeat (2) @(posedge clk);
        rdreg(dwin(8'hFF), rd); chk("R4 mixed read", rd, 32'hC5);
        @(negedge clk); pin_in = 8'hF7;
        @(posedge clk);
        rdreg(dwin(8'hFF), rd); chk("R4 one-edge old", rd, 32'hC5);
        @(posedge clk);
        rdreg(dwin(8'hFF), rd); chk("R4 two-edge new", rd, 32'hC7);
        rdreg(dwin(8'h0A), rd); chk("R4 masked read", rd, 32'h02);

        // R5 level detection on pin0
        wr(A_SEN, 32'h01); wr(A_POL, 32'h01); wr(A_MSK, 32'h01);
        rdreg(A_RAW, rd); chk("R5 high level raw", rd, 32'h01);
        chk("R9 irq level", {31'h0, irq}, 1);
        wr(A_CLR, 32'hFF);
        rdreg(A_RAW, rd); chk("R5 level survives clear", rd, 32'h01);
        wr(A_POL, 32'h00);
        rdreg(A_RAW, rd); chk("R5 low level not met", rd, 32'h00);
        chk("R9 irq off", {31'h0, irq}, 0);
        drive_pins(8'hF6);
        rdreg(A_RAW, rd); chk("R5 low level met", rd, 32'h01);
        wr(A_SEN, 32'h00); wr(A_MSK, 32'h00); wr(A_CLR, 32'hFF);
        rdreg(A_RAW, rd); chk("R8 clear all", rd, 32'h00);

        // R6 rising edge on pin1
        wr(A_POL, 32'h02);
        drive_pins(8'hF4);
        rdreg(A_RAW, rd); chk("R6 falling ignored", rd, 32'h00);
        drive_pins(8'hF6);
        rdreg(A_RAW, rd); chk("R6 rising latched", rd, 32'h02);
        chk("R9 masked off", {31'h0, irq}, 0);
        wr(A_MSK, 32'h02);
        rdreg(A_MIS, rd); chk("R9 mis", rd, 32'h02);
        repeat (5) @(posedge clk);
        #1 chk("R9 irq held", {31'h0, irq}, 1);
        wr(A_CLR, 32'h00);
        rdreg(A_RAW, rd); chk("R8 zero write no effect", rd, 32'h02);
        wr(A_CLR, 32'h02);
        rdreg(A_RAW, rd); chk("R8 w1c", rd, 32'h00);
        chk("R9 irq cleared", {31'h0, irq}, 0);

        // R6 falling edge on pin2
        drive_pins(8'hF2);
        rdreg(A_RAW, rd); chk("R6 falling latched", rd, 32'h04);
        wr(A_CLR, 32'h04);

        // R7 both edges on pin3, polarity set but ignored
        wr(A_BOTH, 32'h08); wr(A_POL, 32'h0A);
        drive_pins(8'hFA);
        rdreg(A_RAW, rd); chk("R7 rise", rd, 32'h08);
        wr(A_CLR, 32'h08);
        drive_pins(8'hF2);
        rdreg(A_RAW, rd); chk("R7 fall", rd, 32'h08);
        wr(A_CLR, 32'h08);
        rdreg(A_RAW, rd); chk("R7 cleared", rd, 32'h00);

        // R8 edge and clear in the same cycle
        drive_pins(8'hF0);
        wr(A_CLR, 32'hFF);
        @(negedge clk); pin_in = 8'hF2;
        @(posedge clk); @(posedge clk);
        wr(A_CLR, 32'h02);
        rdreg(A_RAW, rd); chk("R8 edge beats clear", rd, 32'h02);
        wr(A_CLR, 32'h02);
        rdreg(A_RAW, rd); chk("R8 later clear", rd, 32'h00);

        // R10 unmapped space
        wr(12'h600, 32'hFF);
        wr(12'h42C, 32'hFF);
        rdreg(A_DIR, rd);  chk("R10 dir untouched", rd, 32'hF0);
        rdreg(A_SEN, rd);  chk("R10 sense untouched", rd, 32'h00);
        rdreg(12'h600, rd); chk("R10 unmapped read", rd, 0);
        rdreg(A_CLR, rd);  chk("R10 clear reads zero", rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule